// File: doc/BRIEF.md
# Delayed-Turn-Off Synchronous Rectifier Gate Driver

This block generates the two gate signals for the synchronous-rectifier switches on the secondary of one resonant power stage. A digital polarity input reports the sign of the secondary current. The input is synchronized and then deglitched. In plain rectifier operation each switch would conduct only while the current flows in its direction.

This driver keeps the outgoing switch on for a programmed number of clock cycles after every accepted polarity change. During that time both switches conduct together and short the transformer secondary. Lengthening this window raises the gain of the stage, so one stage can be pushed to take a larger share of a common load. The window is limited by the half period measured between the last two crossings, less a guard interval, so it always closes before the next crossing.

A slow integrator sets the window length from a signed current-share error. It updates once every few switching periods, scales the error by an arithmetic right shift, and saturates the result between zero and a maximum. While the block is disabled, and until two crossings have been accepted after enabling, both gates stay low and the rectifier conducts through its body diodes.

Top module: `sr_delay_driver`

## Requirements
- R1: After reset both gates are low and `delay_val` is 0. While `enable` is low both gates are low, `delay_val` is cleared to 0 and the crossing history is forgotten, so after re-enabling the block must again see two accepted crossings before it drives the gates.
- R2: After `enable` rises, no gate is driven until the second accepted crossing. A gate can switch on from the all-low state only in the cycle that follows an accepted crossing.
- R3: `zc_in` passes through a synchronizer of `SYNC_STAGES` flip-flops (default 2). A new level is accepted only after `blank_len`+1 consecutive synchronized samples of that level. The gates follow the new level at the (`SYNC_STAGES`+`blank_len`+1)-th rising clock edge after the input change. A pulse that is shorter than this is ignored and leaves the gates unchanged.
- R4: Polarity mapping: `zc_in`=1 (positive current) selects `gate_pos`, and `zc_in`=0 selects `gate_neg`. Outside a delay window, an armed and enabled block drives exactly one gate, the one that matches the accepted polarity.
- R5: Starting one cycle after each accepted crossing (from the second one after enable), both gates are high together for exactly D cycles. D = min(`delay_val`, max(T-`GUARD`, 0)), where T is the number of cycles between this accepted crossing and the previous one. This holds for both crossing directions.
- R6: Once the block is armed, every 2·`UPD_PERIODS` accepted crossings the delay becomes `delay_val` + (`share_err` >>> `GAIN_SHIFT`), using a signed arithmetic shift that rounds toward minus infinity. A window opened at an updating crossing uses the delay value from before the update.
- R7: `delay_val` saturates at 0 for a negative result and at `MAX_DELAY` for an overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Enables gate drive and the delay loop |
| zc_in | input | 1 | Asynchronous polarity of secondary current, 1 = positive |
| blank_len | input | BLANK_W | Extra stable samples required before a crossing is accepted |
| share_err | input | ERR_W | Signed current-share error, positive lengthens the delay |
| gate_pos | output | 1 | Gate of the switch that carries positive current |
| gate_neg | output | 1 | Gate of the switch that carries negative current |
| delay_val | output | CNT_W | Present integrator delay in clock cycles |

## Verification
The assertions check on every cycle the properties that hold locally. The accepted polarity changes only together with a crossing pulse. The integrator never exceeds its maximum and reads zero after a disabled cycle. A shorting window only opens right after a crossing and then counts down one step per cycle. Gates only come on after a crossing. What the assertions cannot express needs the bench's scenarios: the exact window length against the measured half period and the clamp, the latency of acceptance through the synchronizer and blanking, rejection of short glitches, the update cadence and rounding of the integrator, and its saturation at both ends.

// File: rtl/sr_drv_pkg.sv
package sr_drv_pkg;
   // accepted polarity of the secondary current
   typedef enum logic {
      POL_NEG = 1'b0,
      POL_POS = 1'b1
   } cur_pol_e;
endpackage

// File: rtl/sr_zc_qualifier.sv
module sr_zc_qualifier
   import sr_drv_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int BLANK_W     = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               zc_raw,
   input  logic [BLANK_W-1:0] blank_len,
   output cur_pol_e           pol,
   output logic               xing
);
   logic [SYNC_STAGES-1:0] sync_q;
   logic [BLANK_W-1:0]     stab_q;
   logic                   zc_s;

   // synchronizer chain, one flop per stage
   generate
      for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) sync_q[0] <= 1'b0;
               else        sync_q[0] <= zc_raw;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) sync_q[s] <= 1'b0;
               else        sync_q[s] <= sync_q[s-1];
            end
         end
      end
   endgenerate

   assign zc_s = sync_q[SYNC_STAGES-1];

   // blanking: new level must persist blank_len+1 samples
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pol    <= POL_NEG;
         stab_q <= '0;
         xing   <= 1'b0;
      end else begin
         xing <= 1'b0;
         if (zc_s != pol) begin
            if (stab_q == blank_len) begin
               pol    <= cur_pol_e'(zc_s);
               stab_q <= '0;
               xing   <= 1'b1;
            end else begin
               stab_q <= stab_q + 1'b1;
            end
         end else begin
            stab_q <= '0;
         end
      end
   end

   assert_xing_flips_pol_R3: assert property (@(posedge clk) disable iff (!rst_n)
      xing |-> (pol != $past(pol)));
   assert_pol_only_on_xing_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !xing |-> $stable(pol));
endmodule

// File: rtl/sr_halfper_meter.sv
module sr_halfper_meter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             xing,
   output logic [CNT_W-1:0] elapsed,
   output logic             have_ref,
   output logic             armed
);
   localparam logic [CNT_W-1:0] CNT_TOP = '1;

   logic [1:0] nx_q;

   // cycles since previous accepted crossing, saturating
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                elapsed <= '0;
      else if (xing)             elapsed <= CNT_W'(1);
      else if (elapsed != CNT_TOP) elapsed <= elapsed + 1'b1;
   end

   // crossings seen since enable, saturating at two
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   nx_q <= 2'd0;
      else if (!enable)             nx_q <= 2'd0;
      else if (xing && nx_q != 2'd2) nx_q <= nx_q + 2'd1;
   end

   assign have_ref = (nx_q != 2'd0);
   assign armed    = (nx_q == 2'd2);

   assert_armed_needs_xing_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(armed) |-> $past(xing));
endmodule

// File: rtl/sr_delay_loop.sv
module sr_delay_loop #(
   parameter int CNT_W       = 16,
   parameter int ERR_W       = 12,
   parameter int GAIN_SHIFT  = 2,
   parameter int UPD_PERIODS = 4,
   parameter int MAX_DELAY   = 1023
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    enable,
   input  logic                    tick,
   input  logic signed [ERR_W-1:0] share_err,
   output logic [CNT_W-1:0]        delay_o
);
   localparam int UPD_XINGS = 2 * UPD_PERIODS;
   localparam int UW        = $clog2(UPD_XINGS + 1);
   localparam int SW        = ((CNT_W > ERR_W) ? CNT_W : ERR_W) + 2;
   localparam logic signed [SW-1:0] MAX_X  = SW'(MAX_DELAY);
   localparam logic [UW-1:0]        UPD_END = UW'(UPD_XINGS - 1);

   logic        [UW-1:0]    ucnt_q;
   logic signed [SW-1:0]    err_x;
   logic signed [SW-1:0]    step;
   logic signed [SW-1:0]    sum;
   logic        [CNT_W-1:0] acc_next;

   assign err_x = {{(SW-ERR_W){share_err[ERR_W-1]}}, share_err};

   // gain variant: plain pass-through or arithmetic shift
   generate
      if (GAIN_SHIFT == 0) begin : g_unity
         assign step = err_x;
      end else begin : g_shift
         assign step = err_x >>> GAIN_SHIFT;
      end
   endgenerate

   assign sum = $signed({{(SW-CNT_W){1'b0}}, delay_o}) + step;

   always_comb begin
      if (sum < 0)          acc_next = '0;
      else if (sum > MAX_X) acc_next = CNT_W'(MAX_DELAY);
      else                  acc_next = sum[CNT_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ucnt_q  <= '0;
         delay_o <= '0;
      end else if (!enable) begin
         ucnt_q  <= '0;
         delay_o <= '0;
      end else if (tick) begin
         if (ucnt_q == UPD_END) begin
            ucnt_q  <= '0;
            delay_o <= acc_next;
         end else begin
            ucnt_q <= ucnt_q + 1'b1;
         end
      end
   end

   assert_clear_when_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> (delay_o == '0));
   assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
      delay_o <= CNT_W'(MAX_DELAY));
endmodule

// File: rtl/sr_gate_timer.sv
module sr_gate_timer
   import sr_drv_pkg::*;
#(
   parameter int CNT_W = 16,
   parameter int GUARD = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  cur_pol_e         pol,
   input  logic             xing,
   input  logic             have_ref,
   input  logic             armed,
   input  logic [CNT_W-1:0] elapsed,
   input  logic [CNT_W-1:0] delay_cmd,
   output logic             gate_pos,
   output logic             gate_neg
);
   localparam logic [CNT_W-1:0] GUARD_C = CNT_W'(GUARD);

   logic [CNT_W-1:0] limit;
   logic [CNT_W-1:0] clamped;
   logic [CNT_W-1:0] hold_q;
   logic             hold_on;
   logic             run;

   // keep the window GUARD cycles clear of the next crossing
   assign limit   = (elapsed > GUARD_C) ? (elapsed - GUARD_C) : '0;
   assign clamped = (delay_cmd < limit) ? delay_cmd : limit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             hold_q <= '0;
      else if (!enable)       hold_q <= '0;
      else if (xing)          hold_q <= have_ref ? clamped : '0;
      else if (hold_q != '0)  hold_q <= hold_q - 1'b1;
   end

   assign hold_on  = (hold_q != '0);
   assign run      = enable && armed;
   assign gate_pos = run && ((pol == POL_POS) || hold_on);
   assign gate_neg = run && ((pol == POL_NEG) || hold_on);

   assert_window_opens_on_xing_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gate_pos && gate_neg) |-> $past(xing));
   assert_window_counts_down_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_on && enable) |=> ($past(xing) || hold_q == '0 || hold_q == $past(hold_q) - 1'b1));
endmodule

// File: rtl/sr_delay_driver.sv
module sr_delay_driver
   import sr_drv_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int BLANK_W     = 6,
   parameter int ERR_W       = 12,
   parameter int SYNC_STAGES = 2,
   parameter int GUARD       = 8,
   parameter int GAIN_SHIFT  = 2,
   parameter int UPD_PERIODS = 4,
   parameter int MAX_DELAY   = 1023
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    enable,
   input  logic                    zc_in,
   input  logic [BLANK_W-1:0]      blank_len,
   input  logic signed [ERR_W-1:0] share_err,
   output logic                    gate_pos,
   output logic                    gate_neg,
   output logic [CNT_W-1:0]        delay_val
);
   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (GUARD < 1 || GUARD >= (1 << (CNT_W - 1))) begin : g_bad_guard
         $error("GUARD out of range for CNT_W");
      end
      if (MAX_DELAY < 1 || MAX_DELAY >= (1 << CNT_W)) begin : g_bad_max
         $error("MAX_DELAY must fit in CNT_W bits");
      end
      if (UPD_PERIODS < 1 || GAIN_SHIFT < 0 || GAIN_SHIFT >= ERR_W) begin : g_bad_loop
         $error("loop parameters out of range");
      end
   endgenerate

   cur_pol_e         pol;
   logic             xing;
   logic [CNT_W-1:0] elapsed;
   logic             have_ref;
   logic             armed;

   sr_zc_qualifier #(
      .SYNC_STAGES (SYNC_STAGES),
      .BLANK_W     (BLANK_W)
   ) u_qual (
      .clk       (clk),
      .rst_n     (rst_n),
      .zc_raw    (zc_in),
      .blank_len (blank_len),
      .pol       (pol),
      .xing      (xing)
   );

   sr_halfper_meter #(
      .CNT_W (CNT_W)
   ) u_meter (
      .clk      (clk),
      .rst_n    (rst_n),
      .enable   (enable),
      .xing     (xing),
      .elapsed  (elapsed),
      .have_ref (have_ref),
      .armed    (armed)
   );

   sr_delay_loop #(
      .CNT_W       (CNT_W),
      .ERR_W       (ERR_W),
      .GAIN_SHIFT  (GAIN_SHIFT),
      .UPD_PERIODS (UPD_PERIODS),
      .MAX_DELAY   (MAX_DELAY)
   ) u_loop (
      .clk       (clk),
      .rst_n     (rst_n),
      .enable    (enable),
      .tick      (xing && armed),
      .share_err (share_err),
      .delay_o   (delay_val)
   );

   sr_gate_timer #(
      .CNT_W (CNT_W),
      .GUARD (GUARD)
   ) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .enable    (enable),
      .pol       (pol),
      .xing      (xing),
      .have_ref  (have_ref),
      .armed     (armed),
      .elapsed   (elapsed),
      .delay_cmd (delay_val),
      .gate_pos  (gate_pos),
      .gate_neg  (gate_neg)
   );

   assert_gates_start_on_xing_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gate_pos || gate_neg) |-> $past(xing));
endmodule

// File: tb/test_sr_delay_driver.sv
module test_sr_delay_driver;
   localparam int CNT_W = 16, BLANK_W = 6, ERR_W = 12;
   localparam int GUARD = 8, GAIN_SHIFT = 2, UPD_PERIODS = 4, MAX_DELAY = 1023;
   localparam int BLANK = 2;
   localparam int LAT   = 2 + BLANK + 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic enable = 1'b0;
   logic zc_in = 1'b0;
   logic [BLANK_W-1:0] blank_len = BLANK_W'(BLANK);
   logic signed [ERR_W-1:0] share_err = '0;
   logic gate_pos, gate_neg;
   logic [CNT_W-1:0] delay_val;

   sr_delay_driver #(
      .CNT_W(CNT_W), .BLANK_W(BLANK_W), .ERR_W(ERR_W), .SYNC_STAGES(2),
      .GUARD(GUARD), .GAIN_SHIFT(GAIN_SHIFT), .UPD_PERIODS(UPD_PERIODS),
      .MAX_DELAY(MAX_DELAY)
   ) i_sr_delay_driver (
      .clk(clk), .rst_n(rst_n), .enable(enable), .zc_in(zc_in),
      .blank_len(blank_len), .share_err(share_err),
      .gate_pos(gate_pos), .gate_neg(gate_neg), .delay_val(delay_val)
   );

   always #2 clk = ~clk;

   int n_chk = 0;
   int n_bad = 0;
   // reference model state
   int m_acc = 0, m_j = 0, m_cnt = 0, m_prev_h = 0, err_val = 0;
   logic lvl = 1'b0;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int model_sat(input int a, input int e);
      int s;
      s = a + (e >>> GAIN_SHIFT);
      if (s < 0) s = 0;
      if (s > MAX_DELAY) s = MAX_DELAY;
      return s;
   endfunction

   function automatic int exp_window(input int acc, input int t);
      int lim;
      lim = (t > GUARD) ? t - GUARD : 0;
      return (acc < lim) ? acc : lim;
   endfunction

   // one half cycle of length h starting with a toggle; optional glitch of gw cycles
   task automatic half(input int h, input int gw);
      int ov;
      int exp_ov;
      logic old;
      ov = 0;
      old = lvl;
      lvl = ~lvl;
      zc_in = lvl;
      m_j++;
      exp_ov = (m_j >= 2) ? exp_window(m_acc, m_prev_h) : 0;
      if (m_j >= 3) begin
         m_cnt++;
         if (m_cnt == 2 * UPD_PERIODS) begin
            m_cnt = 0;
            m_acc = model_sat(m_acc, err_val);
         end
      end
      for (int k = 1; k <= h; k++) begin
         @(negedge clk);
         if (gate_pos && gate_neg) ov++;
         if (m_j >= 3 && k == LAT - 1)   // R3: not yet accepted
            check((lvl ? gate_pos : gate_neg) == 1'b0, "R3 latency early", int'(lvl ? gate_pos : gate_neg), 0);
         if (m_j >= 3 && k == LAT) begin  // R3: accepted, R4: old gate off before window
            check((lvl ? gate_pos : gate_neg) == 1'b1, "R3 latency accept", int'(lvl ? gate_pos : gate_neg), 1);
            check((old ? gate_pos : gate_neg) == 1'b0, "R4 old gate off", int'(old ? gate_pos : gate_neg), 0);
         end
         if (gw > 0 && k == 20) zc_in = ~lvl;
         if (gw > 0 && k == 20 + gw) zc_in = lvl;
      end
      check(ov == exp_ov, "R5 window length", ov, exp_ov);
      if (m_j >= 2) begin
         check(gate_pos == lvl && gate_neg == !lvl, "R4 polarity", {gate_pos, gate_neg}, {lvl, !lvl});
      end else begin
         check(!gate_pos && !gate_neg, "R2 unarmed gates low", {gate_pos, gate_neg}, 0);
      end
      check(int'(delay_val) == m_acc, "R6/R7 delay value", int'(delay_val), m_acc);
      m_prev_h = h;
   endtask

   task automatic restart(input int err);
      enable = 1'b0;
      repeat (3) @(negedge clk);
      check(!gate_pos && !gate_neg && delay_val == '0, "R1 disabled cleared",
            {gate_pos, gate_neg, delay_val}, 0);
      err_val = err;
      share_err = ERR_W'(err);
      m_acc = 0; m_j = 0; m_cnt = 0;
      enable = 1'b1;
      repeat (4) @(negedge clk);
      check(!gate_pos && !gate_neg, "R2 no crossings yet", {gate_pos, gate_neg}, 0);
   endtask

   initial begin
      #(4 * 200000);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      check(!gate_pos && !gate_neg, "R1 reset gates", {gate_pos, gate_neg}, 0);
      check(delay_val == '0, "R1 reset delay", int'(delay_val), 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      // clamp: large error, half period 40 -> window capped at 32 (R5, R6)
      restart(400);
      for (int i = 0; i < 30; i++) half(40, 0);
      // glitches of blank length ignored (R3)
      for (int i = 0; i < 6; i++) half(40, BLANK);
      // saturation high (R7)
      restart(2047);
      for (int i = 0; i < 30; i++) half(24, 0);
      check(int'(delay_val) == MAX_DELAY, "R7 saturate high", int'(delay_val), MAX_DELAY);
      // saturation low, negative rounding (R7, R6)
      err_val = -2048; share_err = ERR_W'(err_val);
      for (int i = 0; i < 24; i++) half(24, 0);
      check(delay_val == '0, "R7 saturate low", int'(delay_val), 0);
      // small unclamped delay with floor rounding (R6)
      restart(-3);
      for (int i = 0; i < 12; i++) half(60, 0);
      err_val = 13; share_err = ERR_W'(err_val);
      for (int i = 0; i < 40; i++) half(60, 0);

      // constrained random bursts
      for (int b = 0; b < 16; b++) begin
         int h;
         restart(int'($urandom_range(1800)) - 600);
         h = 24 + int'($urandom_range(46));
         for (int i = 0; i < 36; i++)
            half(h, (h >= 30 && $urandom_range(3) == 0) ? BLANK : 0);
      end

      // disable mid-run clears history (R1)
      enable = 1'b0;
      @(negedge clk);
      check(!gate_pos && !gate_neg, "R1 disable gates low", {gate_pos, gate_neg}, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule